// File: doc/BRIEF.md
# Key Matrix Scanner with Double-Buffered Key Store

This block reads a 16 x 2 key matrix. The sixteen segment lines double as key sources, and two return inputs report which keys are closed. The display multiplexer raises a key-scan slot strobe once in every frame. While that strobe is high, the block drives one source line at a time, samples both return lines, and stores the results in a 32-bit working store.

A complete scan takes two slots. The first slot after scanning is enabled covers sources 1 to 8, and the next slot covers sources 9 to 16. When the last sample of the second slot is taken, the working store is copied into a read buffer. The read buffer is exposed as four bytes on a byte-read port, and the serial interface shifts each byte out least significant bit first. Because the serial side only ever reads the committed copy, it always sees one whole scan. Scanning stops while the display is off.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, all four bytes of the read buffer are 0x00 (no key pressed), and all source outputs are low.
- R2: While the slot strobe is low, all sixteen source outputs are low.
- R3: Inside a slot, at most one source output is high at any time. Each source is held for SUB_CYCLES clock cycles, and the sources follow one another in ascending order.
- R4: The first slot of a scan cycle drives sources 1..8 (src bits 0..7). The following slot drives sources 9..16 (src bits 8..15), and after that the halves keep alternating.
- R5: The result for source s (1-based) goes into byte (s-1)/4. K1 goes into bit 2*((s-1) mod 4) and K2 into the bit just above it. A 1 means the key is closed. rd_addr selects which byte appears on rd_data.
- R6: The read buffer changes only on the clock edge that takes the final sample of the second slot. A slot that covers only the first half leaves it unchanged.
- R7: While scan_en is low, the source outputs stay low and the read buffer holds its value. When scan_en is raised again, the next slot starts a new cycle with sources 1..8.
- R8: If a slot ends before all eight of its samples are taken, the current cycle is dropped. The read buffer keeps its value, and the next slot starts with sources 1..8.
- R9: A key that is released shows up as 0 after the next complete scan cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | High while the display is on; low halts scanning |
| slot | input | 1 | Key-scan slot strobe from the multiplexer |
| k1 | input | 1 | First key return line |
| k2 | input | 1 | Second key return line |
| rd_addr | input | 2 | Byte select for the read port |
| src | output | 16 | Key source drives, bit n = source n+1 |
| rd_data | output | 8 | Selected byte of the committed key buffer |

## Verification
The assertions assume that the slot strobe only rises and falls between whole frames and that scan_en changes only at clock edges. They also assume the return lines follow the closed keys of whichever source is currently driven, with no delay. The bench models the matrix as a combinational OR of the driven source lines against its own press masks. It drives the strobe for either a full 40-cycle slot or a deliberately short one, and keeps it low for several cycles between slots, so every sub-interval and every abort point is clean.

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
  parameter int SUB_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_en,
  input  logic        slot,
  input  logic        k1,
  input  logic        k2,
  input  logic [1:0]  rd_addr,
  output logic [15:0] src,
  output logic [7:0]  rd_data
);
  localparam int CW = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SUB_CYCLES - 1);

  logic          half;
  logic          done;
  logic [2:0]    idx;
  logic [CW-1:0] cnt;
  logic [31:0]   work;
  logic [31:0]   work_nx;
  logic [31:0]   keys;

  wire       active = scan_en && slot && !done;
  wire [3:0] sel    = {half, idx};
  wire       sample = active && (cnt == CNT_LAST);

  assign src     = active ? (16'd1 << sel) : 16'd0;
  assign rd_data = keys[{rd_addr, 3'b000} +: 8];

  always_comb begin
    work_nx = work;
    work_nx[{sel, 1'b0} +: 2] = {k2, k1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      cnt  <= '0;
      work <= '0;
      keys <= '0;
    end else if (!scan_en) begin
      half <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      cnt  <= '0;
    end else if (slot) begin
      if (!done) begin
        if (sample) begin
          cnt  <= '0;
          work <= work_nx;
          if (idx == 3'd7) begin
            done <= 1'b1;
            idx  <= '0;
            half <= ~half;
            if (half) keys <= work_nx;
          end else begin
            idx <= idx + 3'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      done <= 1'b0;
      idx  <= '0;
      cnt  <= '0;
      if (!done && (idx != 3'd0 || cnt != '0)) half <= 1'b0;
    end
  end
endmodule

// File: rtl/key_scan_checker.sv
module key_scan_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scan_en,
  input logic        slot,
  input logic [15:0] src,
  input logic [31:0] keys
);
  assert_src_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |-> src == 16'd0);

  assert_src_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src));

  assert_src_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src != 16'd0 && $past(src) != 16'd0 && src != $past(src)) |-> src == ($past(src) << 1));

  assert_commit_only_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src[15:8] == 8'd0) |=> $stable(keys));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(keys) && src == 16'd0));
endmodule

bind key_matrix_scanner key_scan_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .slot(slot), .src(src), .keys(keys)
);

// File: tb/sim_key_matrix_scanner.sv
module sim_key_matrix_scanner;
  localparam int SUB  = 4;
  localparam int FULL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        slot = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] press1 = '0;
  logic [15:0] press2 = '0;
  logic [15:0] src;
  logic [7:0]  rd_data;
  logic [31:0] exp_buf = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  wire k1 = |(src & press1);
  wire k2 = |(src & press2);

  always #10 clk = ~clk;

  key_matrix_scanner #(.SUB_CYCLES(SUB)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .slot(slot),
    .k1(k1), .k2(k2), .rd_addr(rd_addr), .src(src), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic read_all(output logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      rd_addr = b[1:0];
      #1;
      v[b*8 +: 8] = rd_data;
    end
  endtask

  function automatic logic [31:0] pack(input logic [15:0] p1, input logic [15:0] p2);
    logic [31:0] v;
    for (int s = 0; s < 16; s++) begin
      v[2*s]   = p1[s];
      v[2*s+1] = p2[s];
    end
    return v;
  endfunction

  task automatic run_slot(input int len, input int hf, input string req);
    int bad = 0;
    logic [15:0] e;
    @(negedge clk);
    slot = 1'b1;
    for (int i = 0; i < len; i++) begin
      #1;
      e = (i < 8*SUB) ? (16'd1 << (hf*8 + i/SUB)) : 16'd0;
      if (src !== e) bad++;
      @(negedge clk);
    end
    slot = 1'b0;
    chk(req, "src sequence mismatches", bad, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic full_cycle(input logic [15:0] p1, input logic [15:0] p2);
    press1 = p1;
    press2 = p2;
    run_slot(FULL, 0, "R4");
    run_slot(FULL, 1, "R4");
    exp_buf = pack(p1, p2);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    read_all(v);
    chk("R1", "buffer after reset", v, 32'd0);
    chk("R1", "src after reset", {16'd0, src}, 32'd0);
  endtask

  task automatic t_idle;
    scan_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2", "src with slot low", {16'd0, src}, 32'd0);
    scan_en = 1'b0;
    slot = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7", "src while disabled", {16'd0, src}, 32'd0);
    slot = 1'b0;
    scan_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pattern(input logic [15:0] p1, input logic [15:0] p2, input string req);
    logic [31:0] v;
    full_cycle(p1, p2);
    read_all(v);
    chk(req, "buffer after full cycle", v, exp_buf);
  endtask

  task automatic t_double;
    logic [31:0] v;
    logic [31:0] old = exp_buf;
    press1 = 16'h00F0;
    press2 = 16'h0F00;
    run_slot(FULL, 0, "R4");
    read_all(v);
    chk("R6", "buffer after first half only", v, old);
    run_slot(FULL, 1, "R4");
    exp_buf = pack(16'h00F0, 16'h0F00);
    read_all(v);
    chk("R6", "buffer after second half", v, exp_buf);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    logic [31:0] old = exp_buf;
    press1 = 16'hFFFF;
    press2 = 16'hFFFF;
    run_slot(FULL, 0, "R4");
    run_slot(10, 1, "R8");
    read_all(v);
    chk("R8", "buffer after short slot", v, old);
    run_slot(FULL, 0, "R8");
    read_all(v);
    chk("R8", "buffer after restarted first half", v, old);
    run_slot(FULL, 1, "R8");
    exp_buf = pack(16'hFFFF, 16'hFFFF);
    read_all(v);
    chk("R8", "buffer after restarted cycle", v, exp_buf);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    logic [31:0] old = exp_buf;
    press1 = 16'h0001;
    press2 = 16'h0000;
    run_slot(FULL, 0, "R4");
    scan_en = 1'b0;
    repeat (4) @(negedge clk);
    read_all(v);
    chk("R7", "buffer while halted", v, old);
    scan_en = 1'b1;
    run_slot(FULL, 0, "R7");
    run_slot(FULL, 1, "R7");
    exp_buf = pack(16'h0001, 16'h0000);
    read_all(v);
    chk("R7", "buffer after re-enable cycle", v, exp_buf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle();
    t_pattern(16'h0001, 16'h0000, "R5");
    t_pattern(16'h0000, 16'h8000, "R5");
    t_pattern(16'hA5C3, 16'h3C5A, "R5");
    t_pattern(16'h0000, 16'h0000, "R9");
    t_double();
    t_abort();
    t_disable();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule